// File: doc/BRIEF.md
# CIC Output Gain Normalizer

This block sits between a CIC interpolation filter and a mixer. It takes the CIC filter's wide signed output and removes the filter's gain. Each valid sample is shifted arithmetically to the right by a programmable amount. The result is rounded and emitted as a 16-bit sample one clock later.

The shift amount comes from an 8-bit gain word that holds two fields: a fine scale and a coarse step worth twelve bits each. A control input picks when a newly written gain word takes hold. In the immediate policy it applies from the next cycle on. In the deferred policy it waits for the first sample that arrives after a sync pulse, so that several channels can switch gain on the same sample.

Top module: `gain_norm_top`

## Requirements
- R1: After reset, out_valid and out_sample are 0, and the gain word is 0x09 (fine scale 9, coarse step 0). The first samples after reset are therefore shifted by 12 bits.
- R2: The gain word carries the fine scale in bits 3:0 and the coarse step in bits 5:4. The shift amount is 3 + fine + 12 × coarse.
- R3: For a shift amount s, the output is the low 16 bits of floor((x + 2^(s-1)) / 2^s), with x taken as signed. Halves round toward positive infinity, and results outside the 16-bit range wrap without saturation or any flag.
- R4: A coarse step value of 3 gives the same shift as a coarse step value of 2.
- R5: out_valid is in_valid delayed by one cycle. In a cycle that follows one without in_valid, out_sample holds its previous value.
- R6: With gain_defer at 0, a gain word written in a cycle applies to samples presented in any later cycle. A sample presented in the same cycle as the write still uses the previous gain.
- R7: With gain_defer at 1, a written gain word does not touch samples until sync_in has been high in some earlier cycle. The first sample after that sync, and every later sample, uses the new word.
- R8: With gain_defer at 1, a sample presented in the same cycle as sync_in uses the gain in force before that sync. The next sample uses the pending word.
- R9: Bits 7:6 of the gain word are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 60 | Signed CIC output sample |
| gain_wr | input | 1 | Gain word write strobe |
| gain_wr_data | input | 8 | Gain word: fine scale in 3:0, coarse step in 5:4, 7:6 unused |
| gain_defer | input | 1 | 0: apply gain writes at once; 1: wait for sync and then a sample |
| sync_in | input | 1 | Sync event pulse |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | 16 | Rounded, normalized signed sample |

## Verification
The shift is tried with exact ties at positive and negative values, to separate round-half-up from truncation and from round-half-away. A large sample that overflows 16 bits shows wrapping rather than clamping. A sweep of every fine scale and coarse step, including coarse value 3, checks how the shift is composed. Sequences of writes, syncs and samples at chosen relative cycles tell the immediate policy from the deferred one. They also show whether a sample in the same cycle as a write or a sync gets the old gain or the new one.

// File: rtl/gain_norm_pkg.sv
package gain_norm_pkg;

  localparam int unsigned GAIN_W = 8;
  localparam logic [7:0]  GAIN_RESET = 8'h09;

  typedef struct packed {
    logic [1:0] coarse;
    logic [3:0] fine;
  } gain_t;

  function automatic gain_t gain_from_word(input logic [GAIN_W-1:0] w);
    gain_t g;
    g.coarse = w[5:4];
    g.fine   = w[3:0];
    return g;
  endfunction

  // coarse value 3 behaves as 2
  function automatic logic [1:0] coarse_clamp(input logic [1:0] c);
    return (c == 2'd3) ? 2'd2 : c;
  endfunction

  // 3 + fine + 12*coarse, built from shifts
  function automatic logic [5:0] shift_of(input gain_t g);
    logic [5:0] c6;
    c6 = {4'b0000, coarse_clamp(g.coarse)};
    return 6'd3 + {2'b00, g.fine} + (c6 << 3) + (c6 << 2);
  endfunction

endpackage

// File: rtl/gain_norm_cfg.sv
module gain_norm_cfg
  import gain_norm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 gain_wr,
  input  logic [GAIN_W-1:0]    gain_wr_data,
  input  logic                 gain_defer,
  input  logic                 sync_in,
  output gain_t                eff_gain
);

  gain_t active_q, pending_q;
  logic  armed_q;
  gain_t wr_gain;
  logic  apply_pending;

  assign wr_gain       = gain_from_word(gain_wr_data);
  assign apply_pending = gain_defer && armed_q && in_valid;
  assign eff_gain      = (gain_defer && armed_q) ? pending_q : active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q  <= gain_from_word(GAIN_RESET);
      pending_q <= gain_from_word(GAIN_RESET);
      armed_q   <= 1'b0;
    end else begin
      if (gain_wr) pending_q <= wr_gain;
      if (gain_wr && !gain_defer) active_q <= wr_gain;
      else if (apply_pending)     active_q <= pending_q;
      armed_q <= gain_defer && (sync_in || (armed_q && !in_valid));
    end
  end

  // R6
  imm_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_wr && !gain_defer) |=> (active_q == $past(gain_wr_data[5:0])));

  // R7
  defer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_defer && !apply_pending) |=> $stable(active_q));

  // R8
  sync_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_defer && sync_in) |=> armed_q);

endmodule

// File: rtl/gain_norm_shifter.sv
module gain_norm_shifter #(
  parameter int unsigned IN_W  = 60,
  parameter int unsigned OUT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_sample,
  input  logic [5:0]              shift_amt,
  output logic                    out_valid,
  output logic [OUT_W-1:0]        out_sample
);

  localparam int unsigned SUM_W = IN_W + 1;

  logic signed [SUM_W-1:0] widened;
  logic signed [SUM_W-1:0] half_lsb;
  logic signed [SUM_W-1:0] biased;
  logic signed [SUM_W-1:0] shifted;

  assign widened  = {in_sample[IN_W-1], in_sample};
  assign half_lsb = $signed({{(SUM_W-1){1'b0}}, 1'b1} << (shift_amt - 6'd1));
  assign biased   = widened + half_lsb;
  assign shifted  = biased >>> shift_amt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_sample <= shifted[OUT_W-1:0];
    end
  end

  // R2
  shift_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (shift_amt >= 6'd3 && shift_amt <= 6'd42));

  // R5
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R5
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_sample)));

endmodule

// File: rtl/gain_norm_top.sv
module gain_norm_top
  import gain_norm_pkg::*;
#(
  parameter int unsigned IN_W  = 60,
  parameter int unsigned OUT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_sample,
  input  logic                    gain_wr,
  input  logic [7:0]              gain_wr_data,
  input  logic                    gain_defer,
  input  logic                    sync_in,
  output logic                    out_valid,
  output logic [OUT_W-1:0]        out_sample
);

  gain_t      eff_gain;
  logic [5:0] shift_amt;

  gain_norm_cfg u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .gain_wr      (gain_wr),
    .gain_wr_data (gain_wr_data),
    .gain_defer   (gain_defer),
    .sync_in      (sync_in),
    .eff_gain     (eff_gain)
  );

  assign shift_amt = shift_of(eff_gain);

  gain_norm_shifter #(.IN_W(IN_W), .OUT_W(OUT_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_sample  (in_sample),
    .shift_amt  (shift_amt),
    .out_valid  (out_valid),
    .out_sample (out_sample)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && out_sample == '0));

endmodule

// File: tb/gain_norm_top_tb_top.sv
`timescale 1ns/1ps
module gain_norm_top_tb_top;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic signed [59:0] in_sample = '0;
  logic               gain_wr = 1'b0;
  logic [7:0]         gain_wr_data = '0;
  logic               gain_defer = 1'b0;
  logic               sync_in = 1'b0;
  logic               out_valid;
  logic [15:0]        out_sample;

  int checks = 0;
  int fails  = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [5:0]  m_act, m_pend;
  bit          m_arm;
  logic [63:0] lfsr = 64'h1234_5678_9ABC_DEF1;

  always #2.5 clk = ~clk;

  gain_norm_top dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .gain_wr(gain_wr), .gain_wr_data(gain_wr_data), .gain_defer(gain_defer),
    .sync_in(sync_in), .out_valid(out_valid), .out_sample(out_sample)
  );

  function automatic logic [15:0] model(input logic signed [59:0] x, input logic [5:0] g);
    int bs = int'(g[5:4]);
    int s;
    longint t;
    if (bs > 2) bs = 2;
    s = 3 + int'(g[3:0]) + 12 * bs;
    t = longint'(x) + (longint'(1) <<< (s - 1));
    t = t >>> s;
    return t[15:0];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic signed [59:0] x, input bit we,
                      input logic [7:0] wd, input bit sy, input bit df, input string tag);
    logic [5:0] eff;
    @(negedge clk);
    in_valid = v; in_sample = x; gain_wr = we; gain_wr_data = wd;
    sync_in = sy; gain_defer = df;
    eff = (df && m_arm) ? m_pend : m_act;
    if (v) begin
      exp_q.push_back(model(x, eff));
      tag_q.push_back(tag);
    end
    if (we && !df)              m_act = wd[5:0];
    else if (df && m_arm && v)  m_act = m_pend;
    if (we) m_pend = wd[5:0];
    m_arm = df && (sy || (m_arm && !v));
  endtask

  task automatic idle(input int n, input bit df);
    for (int i = 0; i < n; i++) step(0, '0, 0, 8'h00, 0, df, "idle");
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) check(0, "R5 unexpected out_valid", out_sample, 16'h0);
      else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(out_sample === e, t, out_sample, e);
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    m_act = 6'h09; m_pend = 6'h09; m_arm = 0;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R1 out_valid in reset", {15'b0, out_valid}, 16'h0);
    check(out_sample === 16'h0, "R1 out_sample in reset", out_sample, 16'h0);
    @(negedge clk); rst_n = 1'b1;

    // R1 default gain -> shift 12
    step(1, 60'sd22528, 0, 0, 0, 0, "R1 default gain");
    // R3 ties and negative values
    step(1, 60'sd2048, 0, 0, 0, 0, "R3 positive tie");
    step(1, -60'sd2048, 0, 0, 0, 0, "R3 negative tie");
    step(1, -60'sd2049, 0, 0, 0, 0, "R3 below negative tie");
    step(1, 60'sd2047, 0, 0, 0, 0, "R3 below positive tie");
    step(1, 60'sd1 <<< 40, 0, 0, 0, 0, "R3 wrap no saturation");
    step(1, (60'sd1 <<< 27) - 60'sd5000, 0, 0, 0, 0, "R3 wrap near limit");
    idle(2, 0);
    step(0, 0, 0, 0, 0, 0, "R5 idle");
    @(negedge clk);
    check(out_valid === 1'b0, "R5 no valid when idle", {15'b0, out_valid}, 16'h0);

    // R2 / R4 sweep, immediate mode
    for (int c = 0; c < 4; c++) begin
      for (int f = 0; f < 16; f++) begin
        step(0, 0, 1, {2'b00, 2'(c), 4'(f)}, 0, 0, "cfg");
        lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
        step(1, $signed(lfsr[59:0]) >>> (c * 3), 0, 0, 0, 0,
             (c == 3) ? "R4 coarse 3 as 2" : "R2 shift composition");
      end
    end

    // R6 write in same cycle as sample uses old gain, next uses new
    step(1, 60'sd123456789, 1, 8'h05, 0, 0, "R6 same-cycle write old gain");
    step(1, 60'sd123456789, 0, 0, 0, 0, "R6 next cycle new gain");
    // R9 upper bits ignored
    step(1, 60'sd987654321, 1, 8'hC1, 0, 0, "R9 old gain");
    step(1, 60'sd987654321, 0, 0, 0, 0, "R9 upper bits ignored");

    // R7 deferred
    step(1, 60'sd123456789, 1, 8'h09, 0, 1, "R7 defer write, old");
    step(1, 60'sd123456789, 0, 0, 0, 1, "R7 pending not applied");
    step(0, 0, 0, 0, 1, 1, "sync");
    step(0, 0, 0, 0, 0, 1, "gap");
    step(1, 60'sd123456789, 0, 0, 0, 1, "R7 first sample after sync");
    step(1, 60'sd123456789, 0, 0, 0, 1, "R7 stays applied");
    // R8 sync together with a sample
    step(0, 0, 1, 8'h1A, 0, 1, "cfg");
    step(1, -60'sd55555555555, 0, 0, 1, 1, "R8 same-cycle sync old gain");
    step(1, -60'sd55555555555, 0, 0, 0, 1, "R8 next sample new gain");
    step(1, -60'sd55555555555, 0, 0, 0, 1, "R8 held");

    idle(4, 0);
    check(exp_q.size() == 0, "R5 all samples emitted", 16'(exp_q.size()), 16'h0);
    finish_run();
  end

endmodule